// File: doc/BRIEF.md
# Modem Control Unit with Selectable Flow-Control Pair

This unit holds the modem-control byte of a serial port and turns it into the two active-low handshake outputs, a request-to-send line and a data-terminal-ready line. Software writes the byte and reads it back through a simple register port. Each output line either acts as a general-purpose pin that software sets, or, when automatic hardware flow control is on, is throttled by the receive FIFO level. A single select bit chooses which output and input pair carries the throttling. The request line pairs with clear-to-send. The terminal-ready line pairs with data-set-ready.

The four modem inputs (clear-to-send, data-set-ready, carrier detect, ring indicator) arrive active-low and asynchronous. They are synchronized and presented as active-high status bits. A transmit-allow output tells the transmitter whether the paired input currently permits sending.

In local loopback mode the unit parks both external outputs at their inactive high level. The status bits then come from the control byte itself, and the pair-select and send-immediate bits serve as the two spare loopback outputs that feed ring indicator and carrier detect.

Top module: `mdm_ctl_unit`

## Requirements
- R1: After a synchronous reset the control byte reads 0x00, both `rts_n_o` and `dtr_n_o` are high, the throttle state is released, and with all modem inputs high the status reads 0.
- R2: A write stores wr_data bits 4..0 (bit 0 terminal-ready, bit 1 request, bit 2 pair select, bit 3 send-immediate, bit 4 loopback). Bits 7..5 of a write are ignored and read back as 0. `rd_data` shows the stored byte from the cycle after the write.
- R3: Outside loopback, when the request line is neither selected nor throttled, control bit 1 = 1 drives `rts_n_o` low and bit 1 = 0 drives it high.
- R4: Outside loopback, when the terminal-ready line is neither selected nor throttled, control bit 0 = 1 drives `dtr_n_o` low and bit 0 = 0 drives it high.
- R5: With `afc_en` high, pair select 0 makes the request line the throttled output and leaves terminal-ready as a general-purpose pin. Pair select 1 does the reverse.
- R6: The throttle state is set in the cycle after `rx_hi` is high. It is cleared in the cycle after `rx_lo` is high while `rx_hi` is low, and otherwise keeps its value, with `rx_hi` taking priority. While the state is set and `afc_en` is high, the selected output is held high.
- R7: With `afc_en` low and loopback off, both outputs follow their control bits whatever the throttle state is.
- R8: With `afc_en` low, `tx_allow` is 1. With `afc_en` high, `tx_allow` equals the clear-to-send status bit when pair select is 0 and the data-set-ready status bit when pair select is 1.
- R9: Outside loopback, `mstat` = {cd, ri, dsr, cts} (bit 3 down to bit 0) is the inverse of the matching input pins. It is delayed by SYNC_STAGES clock edges and is unchanged one edge after a pin changes (default 2).
- R10: In loopback (bit 4 = 1), `rts_n_o` and `dtr_n_o` are both high.
- R11: In loopback, the cts status equals control bit 1, dsr equals bit 0, ri equals bit 2 and cd equals bit 3, and the input pins have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Stored control byte, unused bits zero |
| afc_en | input | 1 | Automatic hardware flow control enable |
| rx_hi | input | 1 | Receive FIFO at upper threshold |
| rx_lo | input | 1 | Receive FIFO at or below lower threshold |
| cts_n_i | input | 1 | Clear-to-send input, active low |
| dsr_n_i | input | 1 | Data-set-ready input, active low |
| dcd_n_i | input | 1 | Carrier-detect input, active low |
| ri_n_i | input | 1 | Ring-indicator input, active low |
| rts_n_o | output | 1 | Request-to-send output, active low |
| dtr_n_o | output | 1 | Terminal-ready output, active low |
| tx_allow | output | 1 | Transmitter may send |
| mstat | output | 4 | Status {cd, ri, dsr, cts}, active high |

## Verification
On every cycle the embedded properties check several rules. The loopback pins must stay parked high. Write data must appear masked on the readback. Outputs must follow their bits when flow control is off. The throttle state must set and clear as the threshold inputs demand. Loopback status must mirror the control bits. Transmit must be blocked when the paired input is deasserted. The scenarios alone show the synchronizer latency, the hand-over of throttling from one pair to the other when the select bit flips while the throttle is held, and the `rx_hi` priority when both thresholds are asserted together.

// File: rtl/mdm_ctl_pkg.sv
// Package: shared types for the modem control unit.
// Assumes: control field order matches the software-visible byte layout.
package mdm_ctl_pkg;
    // Control byte fields, bit 4 down to bit 0.
    typedef struct packed {
        logic loopb;     // bit 4: local loopback
        logic op2;       // bit 3: send-immediate / loopback spare output 2
        logic pair_dtr;  // bit 2: pair select / loopback spare output 1
        logic rts_on;    // bit 1: request line asserted
        logic dtr_on;    // bit 0: terminal-ready line asserted
    } ctl_t;

    // Modem status, active high, bit 3 down to bit 0.
    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } mstat_t;

    localparam int CTL_FIELD_W = $bits(ctl_t);
    localparam int STAT_W      = $bits(mstat_t);
endpackage

// File: rtl/mdm_ctl_reg.sv
// Module: control byte storage with readback.
// Assumes: REG_W is at least the field width; unused bits read as zero.
module mdm_ctl_reg
    import mdm_ctl_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_t             ctl_o,
    output logic [REG_W-1:0] rd_data_o
);
    localparam int PAD_W = REG_W - CTL_FIELD_W;

    ctl_t ctl_q;

    // Capture the writable fields; reserved bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_en)
            ctl_q <= ctl_t'(wr_data[CTL_FIELD_W-1:0]);
    end

    assign ctl_o     = ctl_q;
    assign rd_data_o = {{PAD_W{1'b0}}, ctl_q};

    // R2: readback equals written fields with reserved bits zero.
    assert_wr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data_o == {{PAD_W{1'b0}}, $past(wr_data[CTL_FIELD_W-1:0])});
endmodule

// File: rtl/mdm_pin_sync.sv
// Module: multi-stage synchronizer for active-low asynchronous inputs.
// Assumes: inputs idle high; output is active high after STAGES edges.
module mdm_pin_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_n_i,
    output logic [N-1:0] act_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        // Shift the raw pin level through the stage chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain_q <= '1;
            else if (STAGES == 1)
                chain_q <= pin_n_i[b];
            else
                chain_q <= {chain_q[STAGES-2:0], pin_n_i[b]};
        end
        assign act_o[b] = ~chain_q[STAGES-1];
    end
endmodule

// File: rtl/mdm_stat_mux.sv
// Module: picks the modem status source, external pins or loopback bits.
// Assumes: ext_i is already synchronized and active high.
module mdm_stat_mux
    import mdm_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ctl_t   ctl_i,
    input  mstat_t ext_i,
    output mstat_t stat_o
);
    mstat_t loop_stat;

    // Route the control bits onto the status positions in loopback.
    always_comb begin
        loop_stat.cts = ctl_i.rts_on;
        loop_stat.dsr = ctl_i.dtr_on;
        loop_stat.ri  = ctl_i.pair_dtr;
        loop_stat.cd  = ctl_i.op2;
        stat_o        = ctl_i.loopb ? loop_stat : ext_i;
    end

    // R11: loopback status mirrors the control fields.
    assert_loop_stat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.loopb |-> stat_o.cts == ctl_i.rts_on && stat_o.dsr == ctl_i.dtr_on
                        && stat_o.ri == ctl_i.pair_dtr && stat_o.cd == ctl_i.op2);
endmodule

// File: rtl/mdm_flow_gate.sv
// Module: throttle hysteresis, output pin drive and transmit permission.
// Assumes: rx_hi/rx_lo are synchronous level indications from the FIFO.
module mdm_flow_gate
    import mdm_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   afc_en,
    input  logic   rx_hi,
    input  logic   rx_lo,
    input  ctl_t   ctl_i,
    input  mstat_t stat_i,
    output logic   rts_n_o,
    output logic   dtr_n_o,
    output logic   tx_allow_o
);
    logic hold_q;
    logic rts_act, dtr_act;

    // Hysteresis: upper threshold sets, lower threshold clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (rx_hi)
            hold_q <= 1'b1;
        else if (rx_lo)
            hold_q <= 1'b0;
    end

    // Derive active levels, park pins in loopback, gate transmit.
    always_comb begin
        rts_act = ctl_i.rts_on && !(afc_en && !ctl_i.pair_dtr && hold_q);
        dtr_act = ctl_i.dtr_on && !(afc_en &&  ctl_i.pair_dtr && hold_q);
        rts_n_o = ctl_i.loopb ? 1'b1 : !rts_act;
        dtr_n_o = ctl_i.loopb ? 1'b1 : !dtr_act;
        if (!afc_en)
            tx_allow_o = 1'b1;
        else
            tx_allow_o = ctl_i.pair_dtr ? stat_i.dsr : stat_i.cts;
    end

    // R6: throttle state follows the thresholds one cycle later.
    assert_hold_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hi |=> hold_q);
    assert_hold_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_hi && rx_lo) |=> !hold_q);
    // R8: a deasserted paired input blocks transmission.
    assert_tx_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (afc_en && ((ctl_i.pair_dtr && !stat_i.dsr) || (!ctl_i.pair_dtr && !stat_i.cts)))
        |-> !tx_allow_o);
endmodule

// File: rtl/mdm_ctl_unit.sv
// Module: top of the modem control unit.
// Assumes: modem inputs asynchronous, active low; all outputs combinational
// from registered state so they change in the cycle after a write.
module mdm_ctl_unit
    import mdm_ctl_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             afc_en,
    input  logic             rx_hi,
    input  logic             rx_lo,
    input  logic             cts_n_i,
    input  logic             dsr_n_i,
    input  logic             dcd_n_i,
    input  logic             ri_n_i,
    output logic             rts_n_o,
    output logic             dtr_n_o,
    output logic             tx_allow,
    output logic [3:0]       mstat
);
    ctl_t              ctl;
    mstat_t            ext_stat, stat;
    logic [STAT_W-1:0] ext_act;

    mdm_ctl_reg #(.REG_W(REG_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ctl_o(ctl), .rd_data_o(rd_data)
    );

    mdm_pin_sync #(.N(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_n_i({dcd_n_i, ri_n_i, dsr_n_i, cts_n_i}),
        .act_o(ext_act)
    );
    assign ext_stat = mstat_t'(ext_act);

    mdm_stat_mux u_mux (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .ext_i(ext_stat), .stat_o(stat)
    );

    mdm_flow_gate u_gate (
        .clk(clk), .rst_n(rst_n), .afc_en(afc_en), .rx_hi(rx_hi), .rx_lo(rx_lo),
        .ctl_i(ctl), .stat_i(stat),
        .rts_n_o(rts_n_o), .dtr_n_o(dtr_n_o), .tx_allow_o(tx_allow)
    );

    assign mstat = stat;

    // R10: loopback parks both outputs high.
    assert_loop_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> rts_n_o && dtr_n_o);
    // R7: with flow control off, outputs follow the readback bits.
    assert_gp_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!afc_en && !rd_data[4]) |-> rts_n_o == !rd_data[1] && dtr_n_o == !rd_data[0]);
endmodule

// File: tb/mdm_ctl_unit_bench.sv
module mdm_ctl_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       afc_en = 1'b0, rx_hi = 1'b0, rx_lo = 1'b0;
    logic       cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1, ri_n = 1'b1;
    logic       rts_n, dtr_n, tx_allow;
    logic [3:0] mstat;

    always #10 clk = ~clk;

    mdm_ctl_unit u_mdm_ctl_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .afc_en(afc_en), .rx_hi(rx_hi), .rx_lo(rx_lo),
        .cts_n_i(cts_n), .dsr_n_i(dsr_n), .dcd_n_i(dcd_n), .ri_n_i(ri_n),
        .rts_n_o(rts_n), .dtr_n_o(dtr_n), .tx_allow(tx_allow), .mstat(mstat)
    );

    typedef struct {
        string       tag;
        logic [14:0] exp;
    } item_t;

    item_t q[$];
    int    pend = 0;
    int    checks = 0, errors = 0;
    bit    done = 1'b0;

    // Requirement-level expectations kept by the bench.
    logic [4:0] m_ctl = '0;
    logic       m_hold = 1'b0;

    function automatic logic [14:0] model();
        logic [3:0] st;
        logic       ra, da, rn, dn, tx;
        if (m_ctl[4]) st = {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]};
        else          st = {~dcd_n, ~ri_n, ~dsr_n, ~cts_n};
        ra = m_ctl[1] & ~(afc_en & ~m_ctl[2] & m_hold);
        da = m_ctl[0] & ~(afc_en &  m_ctl[2] & m_hold);
        rn = m_ctl[4] ? 1'b1 : ~ra;
        dn = m_ctl[4] ? 1'b1 : ~da;
        tx = afc_en ? (m_ctl[2] ? st[1] : st[0]) : 1'b1;
        return {3'b000, m_ctl, rn, dn, tx, st};
    endfunction

    // Driver side: push an expectation and wait for the monitor to take it.
    task automatic chk(input string tag);
        item_t it;
        it.tag = tag;
        it.exp = model();
        q.push_back(it);
        pend++;
        wait (pend == 0);
    endtask

    // Same as chk but with an explicit expected status (latency checks).
    task automatic chk_stat(input string tag, input logic [3:0] st);
        item_t it;
        it.tag = tag;
        it.exp = model();
        it.exp[3:0] = st;
        q.push_back(it);
        pend++;
        wait (pend == 0);
    endtask

    // Monitor: pop and compare against the live outputs.
    initial begin
        forever begin
            wait (pend != 0);
            #1;
            begin
                item_t it;
                logic [14:0] act;
                it  = q.pop_front();
                act = {rd_data, rts_n, dtr_n, tx_allow, mstat};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
                pend--;
            end
        end
    end

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_ctl = d[4:0];
    endtask

    task automatic thr(input logic h, input logic l);
        @(negedge clk);
        rx_hi = h; rx_lo = l;
        @(negedge clk);
        rx_hi = 1'b0; rx_lo = 1'b0;
        if (h) m_hold = 1'b1;
        else if (l) m_hold = 1'b0;
    endtask

    task automatic pins(input logic c, input logic d, input logic cd, input logic r);
        @(negedge clk);
        cts_n = c; dsr_n = d; dcd_n = cd; ri_n = r;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state");

        wr(8'hE3); chk("R2 reserved bits dropped, R3 R4 both low");
        wr(8'h02); chk("R3 rts low dtr high");
        wr(8'h01); chk("R4 dtr low rts high");
        wr(8'h00); chk("R3 R4 both high");

        // R9 synchronizer latency
        @(negedge clk); cts_n = 1'b0;
        @(negedge clk); chk_stat("R9 unchanged after one edge", 4'b0000);
        @(negedge clk); chk("R9 cts visible after two edges");
        pins(1'b1, 1'b0, 1'b0, 1'b1); chk("R9 dsr and cd");
        pins(1'b1, 1'b1, 1'b1, 1'b0); chk("R9 ri");

        // R8 transmit permission
        pins(1'b0, 1'b1, 1'b1, 1'b1); chk("R8 afc off tx allowed");
        @(negedge clk); afc_en = 1'b1; chk("R8 sel0 cts asserted");
        pins(1'b1, 1'b0, 1'b1, 1'b1); chk("R8 sel0 cts deasserted blocks");
        wr(8'h04); chk("R8 sel1 dsr asserted allows");

        // R5 R6 throttling
        wr(8'h03); chk("R5 sel0 both active");
        thr(1'b1, 1'b0); chk("R6 R5 upper threshold throttles rts only");
        thr(1'b0, 1'b0); chk("R6 hold kept");
        thr(1'b0, 1'b1); chk("R6 lower threshold releases");
        thr(1'b1, 1'b1); chk("R6 upper wins over lower");
        wr(8'h07); chk("R5 sel1 throttles dtr only");
        @(negedge clk); afc_en = 1'b0; chk("R7 afc off ignores hold");
        @(negedge clk); afc_en = 1'b1; chk("R5 afc back on");
        thr(1'b0, 1'b1); chk("R6 released sel1");

        // R10 R11 loopback
        wr(8'h1F); chk("R10 R11 loopback all bits");
        wr(8'h15); chk("R10 R11 loopback mixed");
        pins(1'b0, 1'b0, 1'b0, 1'b0); chk("R11 pins ignored in loopback");
        wr(8'h0A); chk("R11 exit loopback status from pins");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule